// File: doc/BRIEF.md
# Strap-Latched Status LED Controller

This block owns a small group of shared pads. While power-up reset is held, it reads them as configuration straps. It captures a five-bit management address from the shared pads and three mode straps from their own pins: speed, duplex and auto-negotiation enable. Once reset is released, the block turns the low three shared pads into LED drivers. Each driver's active level is the opposite of the level that pad held during reset. A board can therefore set an address bit with a pull-up or pull-down and still wire the LED to the matching rail.

Two small state machines do the work.

The capture machine has two states:
- `CAP_SAMPLE` is forced while reset is low.
- `CAP_DRIVE` is entered on the first clock edge after release and held from then on.

The activity machine has two states:
- In `BLK_IDLE`, an activity pulse starts a blink and moves the machine to `BLK_FLASH`.
- In `BLK_FLASH`, a retriggerable stretch counter counts down while a phase counter splits time into phases of 2^BLINK_LOG2 clocks.
- At a phase boundary with the stretch count exhausted and no new activity, the machine returns to `BLK_IDLE`.
- Otherwise, at a phase boundary, the blink level toggles and the machine stays in `BLK_FLASH`.

The three LEDs show:
- The link LED shows link state.
- The duplex LED shows full duplex.
- The activity LED has two modes. In the activity-only mode its resting state is off. In the combined mode its resting state is "linked at 10 Mb/s". In both modes, activity inverts the resting state in alternate phases.

Top module: `strap_led_ctrl`

## Requirements
- R1: While `rst_n` is low, `phy_addr` follows `pin_in` on every clock edge. After release it holds the value sampled at the last edge in reset, whatever `pin_in` does later.
- R2: `cfg_speed100`, `cfg_full_duplex` and `cfg_autoneg` are captured from `strap_speed`, `strap_duplex` and `strap_aneg` under the same rule as R1, and are constant outside reset.
- R3: Output enables:
  - `pin_oe` is all zero while reset is low and after release until the first rising clock edge.
  - From that edge on, `pin_oe` bits 0, 1 and 2 are 1.
  - Bits 3 and 4 of `pin_oe` and `pin_out` stay 0 at all times.
- R4: For each LED pin k (0 to 2), `pin_out[k]` equals "LED k lit" XOR `phy_addr[k]`. A pad strapped high is therefore active low, and a pad strapped low is active high.
- R5: LED 0 is lit exactly when `link_up` is 1.
- R6: LED 1 is lit exactly when `full_dup` is 1.
- R7: With `led_mode` = 0, LED 2 rests unlit. A `tx_act` or `rx_act` pulse seen at an edge while idle lights it for 2^BLINK_LOG2 cycles starting after that edge. Blinking then alternates in phases of that length.
- R8: With `led_mode` = 1, LED 2 rests lit exactly when `link_up` and `spd_10` are both 1. Activity inverts this resting level in the first phase and in every second phase after it.
- R9: Stretch and exit:
  - Every edge with activity reloads a stretch count of STRETCH_CYC.
  - Every other blinking edge decrements the count towards zero.
  - The blink ends only at a phase boundary where the count is zero and no activity is present. LED 2 then returns to its resting level with no shortened phase.
- R10: Activity at the very phase boundary where the blink would have ended keeps it going: the level toggles and the stretch count reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low; straps are sampled while low |
| link_up | input | 1 | Link established |
| full_dup | input | 1 | Link operating in full duplex |
| spd_10 | input | 1 | Link operating at 10 Mb/s |
| tx_act | input | 1 | Transmit activity pulse |
| rx_act | input | 1 | Receive activity pulse |
| led_mode | input | 1 | 0: LED 2 shows activity only; 1: LED 2 shows 10 Mb/s link plus activity |
| pin_in | input | ADDR_W | Pad input levels of the shared pins |
| strap_speed | input | 1 | Speed strap level |
| strap_duplex | input | 1 | Duplex strap level |
| strap_aneg | input | 1 | Auto-negotiation enable strap level |
| phy_addr | output | ADDR_W | Latched management address |
| cfg_speed100 | output | 1 | Latched speed strap |
| cfg_full_duplex | output | 1 | Latched duplex strap |
| cfg_autoneg | output | 1 | Latched auto-negotiation strap |
| pin_out | output | ADDR_W | Pad output levels |
| pin_oe | output | ADDR_W | Pad output enables |

## Verification
The stretch expiry and a new activity retrigger can fall on the same clock edge: the phase-end edge where the stretch count has just reached zero. The bench times a transmit pulse for exactly that edge, eight cycles after a single pulse with a stretch of six and phases of four. It then checks that LED 2 starts a fresh lit phase instead of settling at rest. It also checks the matching case without the coincident pulse, in which the same edge returns LED 2 to its resting level.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
    // Capture machine: sampling straps in reset, driving LEDs afterwards.
    typedef enum logic {
        CAP_SAMPLE = 1'b0,
        CAP_DRIVE  = 1'b1
    } cap_state_e;

    // Activity machine: resting level or blinking.
    typedef enum logic {
        BLK_IDLE  = 1'b0,
        BLK_FLASH = 1'b1
    } blk_state_e;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_led_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int CFG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pin_in,
    input  logic [CFG_W-1:0]  cfg_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic              drive
);
    cap_state_e st_q, st_d;

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAP_SAMPLE: st_d = CAP_DRIVE;
            CAP_DRIVE:  st_d = CAP_DRIVE;
        endcase
    end

    // State register; reset forces sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CAP_SAMPLE;
        else        st_q <= st_d;
    end

    // Straps follow the pads only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= pin_in;
            cfg_q  <= cfg_in;
        end
    end

    // Outputs.
    always_comb begin
        drive = (st_q == CAP_DRIVE);
    end

    // R1: address frozen once out of reset
    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(addr_q));
    // R2: mode straps frozen once out of reset
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));
    // R3: drivers come on one edge after release and stay on
    p_drive_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |=> drive);
endmodule

// File: rtl/act_blinker.sv
module act_blinker
    import strap_led_pkg::*;
#(
    parameter int BLINK_LOG2  = 21,
    parameter int STRETCH_CYC = 8388608
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic steady,
    output logic led
);
    localparam int CNT_W = $clog2(STRETCH_CYC + 1);
    localparam logic [BLINK_LOG2-1:0] PH_LAST = '1;
    localparam logic [CNT_W-1:0]      RELOAD  = CNT_W'(STRETCH_CYC);

    blk_state_e            st_q, st_d;
    logic [BLINK_LOG2-1:0] ph_q, ph_d;
    logic [CNT_W-1:0]      hold_q, hold_d;
    logic                  inv_q, inv_d;
    logic                  ph_end;

    always_comb ph_end = (ph_q == PH_LAST);

    // Next-state logic.
    always_comb begin
        st_d   = st_q;
        ph_d   = ph_q;
        hold_d = hold_q;
        inv_d  = inv_q;
        unique case (st_q)
            BLK_IDLE: begin
                if (act) begin
                    st_d   = BLK_FLASH;
                    ph_d   = '0;
                    inv_d  = 1'b1;
                    hold_d = RELOAD;
                end
            end
            BLK_FLASH: begin
                ph_d = ph_q + 1'b1;
                if (act)                 hold_d = RELOAD;
                else if (hold_q != '0)   hold_d = hold_q - 1'b1;
                if (ph_end) begin
                    if (!act && hold_q == '0) begin
                        st_d  = BLK_IDLE;
                        inv_d = 1'b0;
                        ph_d  = '0;
                    end else begin
                        inv_d = ~inv_q;
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BLK_IDLE;
            ph_q   <= '0;
            hold_q <= '0;
            inv_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            ph_q   <= ph_d;
            hold_q <= hold_d;
            inv_q  <= inv_d;
        end
    end

    // Outputs.
    always_comb begin
        led = steady ^ ((st_q == BLK_FLASH) && inv_q);
    end

    // R7: any activity leaves the machine blinking
    p_enter_flash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> (st_q == BLK_FLASH));
    // R9: blinking only ends on a phase boundary
    p_exit_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BLK_FLASH && !ph_end) |=> (st_q == BLK_FLASH));
    // R9: idle carries no partial phase
    p_idle_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BLK_IDLE) |-> (ph_q == '0 && !inv_q));
    // R9: stretch count never exceeds its reload
    p_hold_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q <= RELOAD);
    // R10: activity at a boundary toggles the level
    p_retrig_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BLK_FLASH && ph_end && act) |=> (inv_q != $past(inv_q)));
endmodule

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl
    import strap_led_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int BLINK_LOG2  = 21,
    parameter int STRETCH_CYC = 8388608
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up,
    input  logic              full_dup,
    input  logic              spd_10,
    input  logic              tx_act,
    input  logic              rx_act,
    input  logic              led_mode,
    input  logic [ADDR_W-1:0] pin_in,
    input  logic              strap_speed,
    input  logic              strap_duplex,
    input  logic              strap_aneg,
    output logic [ADDR_W-1:0] phy_addr,
    output logic              cfg_speed100,
    output logic              cfg_full_duplex,
    output logic              cfg_autoneg,
    output logic [ADDR_W-1:0] pin_out,
    output logic [ADDR_W-1:0] pin_oe
);
    localparam int LED_NUM = 3;
    localparam int CFG_W   = 3;

    logic [LED_NUM-1:0] led_lit;
    logic [CFG_W-1:0]   cfg_q;
    logic               drive;
    logic               led2_rest;
    logic               led2;

    strap_capture #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .cfg_in ({strap_aneg, strap_duplex, strap_speed}),
        .addr_q (phy_addr),
        .cfg_q  (cfg_q),
        .drive  (drive)
    );

    assign cfg_speed100    = cfg_q[0];
    assign cfg_full_duplex = cfg_q[1];
    assign cfg_autoneg     = cfg_q[2];

    always_comb led2_rest = led_mode & link_up & spd_10;

    act_blinker #(.BLINK_LOG2(BLINK_LOG2), .STRETCH_CYC(STRETCH_CYC)) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (tx_act | rx_act),
        .steady (led2_rest),
        .led    (led2)
    );

    assign led_lit = {led2, full_dup, link_up};

    for (genvar k = 0; k < ADDR_W; k++) begin : g_pad
        if (k < LED_NUM) begin : g_led
            assign pin_out[k] = led_lit[k] ^ phy_addr[k];
            assign pin_oe[k]  = drive;
        end else begin : g_addr_only
            assign pin_out[k] = 1'b0;
            assign pin_oe[k]  = 1'b0;
        end
    end

    // R5: link pad shows link state at the polarity its strap chose
    p_link_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe[0] |-> ((pin_out[0] ^ phy_addr[0]) == link_up));
endmodule

// File: tb/test_strap_led_ctrl.sv
module test_strap_led_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_up = 0, full_dup = 0, spd_10 = 0, tx_act = 0, rx_act = 0, led_mode = 0;
    logic [4:0] pin_in = 5'b0;
    logic       strap_speed = 0, strap_duplex = 0, strap_aneg = 0;
    logic [4:0] phy_addr, pin_out, pin_oe;
    logic       cfg_speed100, cfg_full_duplex, cfg_autoneg;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    strap_led_ctrl #(.ADDR_W(5), .BLINK_LOG2(2), .STRETCH_CYC(6)) i_strap_led_ctrl (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .full_dup(full_dup),
        .spd_10(spd_10), .tx_act(tx_act), .rx_act(rx_act), .led_mode(led_mode),
        .pin_in(pin_in), .strap_speed(strap_speed), .strap_duplex(strap_duplex),
        .strap_aneg(strap_aneg), .phy_addr(phy_addr), .cfg_speed100(cfg_speed100),
        .cfg_full_duplex(cfg_full_duplex), .cfg_autoneg(cfg_autoneg),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {link, fd, s10, mode, tx, rx, lit2, lit1, lit0}; phases of 4, stretch 6
    localparam logic [8:0] VEC [0:41] = '{
        9'b000000_000, 9'b100000_001, 9'b110000_011, 9'b110010_111,
        9'b110000_111, 9'b110000_111, 9'b110000_111, 9'b110000_011,
        9'b110000_011, 9'b110000_011, 9'b110000_011, 9'b110000_011,
        9'b110000_011, 9'b101100_101, 9'b101101_001, 9'b101100_001,
        9'b101100_001, 9'b101100_001, 9'b101100_101, 9'b101110_101,
        9'b101100_101, 9'b101100_101, 9'b101100_001, 9'b101100_001,
        9'b101100_001, 9'b101100_001, 9'b101100_101, 9'b101100_101,
        9'b100100_001, 9'b100010_101, 9'b100000_101, 9'b100000_101,
        9'b100000_101, 9'b100000_001, 9'b100000_001, 9'b100000_001,
        9'b100000_001, 9'b100010_101, 9'b100000_101, 9'b100000_101,
        9'b100000_101, 9'b100000_001
    };

    function automatic string led2_req(input int idx);
        if (idx < 13)      return "R7";
        else if (idx < 19) return "R8";
        else if (idx < 29) return "R9";
        else if (idx < 37) return "R7";
        else               return "R10";
    endfunction

    localparam logic [4:0] STRAP_A = 5'b10110;
    localparam logic [4:0] STRAP_B = 5'b01001;

    initial begin
        // Reset phase: pads move, drivers stay off.
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 oe in reset", pin_oe, 5'b00000);
        pin_in = STRAP_A;
        strap_speed = 1; strap_duplex = 0; strap_aneg = 1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R3 oe before first edge", pin_oe, 5'b00000);
        @(negedge clk);
        check("R3 oe after release", pin_oe, 5'b00111);
        check("R1 addr latched", phy_addr, STRAP_A);
        check("R2 straps latched", {cfg_autoneg, cfg_full_duplex, cfg_speed100}, 3'b101);
        // Pads and straps change after reset: nothing may follow.
        pin_in = 5'b01010;
        strap_speed = 0; strap_duplex = 1; strap_aneg = 0;
        repeat (3) @(negedge clk);
        check("R1 addr held", phy_addr, STRAP_A);
        check("R2 straps held", {cfg_autoneg, cfg_full_duplex, cfg_speed100}, 3'b101);

        // Vector walk.
        for (int i = 0; i < 42; i++) begin
            @(negedge clk);
            {link_up, full_dup, spd_10, led_mode, tx_act, rx_act} = VEC[i][8:3];
            @(posedge clk);
            #1;
            check("R5 led0", pin_out[0], VEC[i][0] ^ STRAP_A[0]);
            check("R6 led1", pin_out[1], VEC[i][1] ^ STRAP_A[1]);
            check({led2_req(i), " led2"}, pin_out[2], VEC[i][2] ^ STRAP_A[2]);
            check("R3 unused pads", {pin_oe[4:3], pin_out[4:3]}, 4'b0000);
        end

        // Second reset with opposite polarity straps.
        @(negedge clk);
        tx_act = 0; rx_act = 0; led_mode = 0;
        rst_n = 1'b0;
        pin_in = STRAP_B;
        strap_speed = 0; strap_duplex = 1; strap_aneg = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3 oe in second reset", pin_oe, 5'b00000);
        rst_n = 1'b1;
        link_up = 1; full_dup = 0;
        @(negedge clk);
        check("R1 addr recaptured", phy_addr, STRAP_B);
        check("R2 straps recaptured", {cfg_autoneg, cfg_full_duplex, cfg_speed100}, 3'b010);
        check("R4 led0 active low", pin_out[0], 1'b0);
        check("R4 led1 active high", pin_out[1], 1'b0);
        check("R4 led2 idle active high", pin_out[2], 1'b0);
        link_up = 0;
        #1;
        check("R4 led0 unlit high", pin_out[0], 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule